// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

The block gathers 32 external interrupt lines and folds them onto a small set of shared vector bits, one for each priority. Every source owns a pair of table words. The low word is a delivery mask for threads, stored for software. The high word decides whether the source takes part at all, whether it is edge or level sensitive, which polarity counts as active, and which vector bit it drives. Inputs pass through a two-flop synchronizer before detection. Each source keeps a latched request that software clears by writing a one-hot mask to an acknowledge address.

A vector bit in the pending register rises whenever at least one valid source mapped to it holds a request. It stays set until the vector-clear input removes it. A clear does not discard live requests: the pending bit is recomputed from the requests still latched, so the usual order is to acknowledge the sources first and then clear the vector. Table words are written and read over a simple single-cycle register port. Reads are combinational.

Top module: `irt_ctrl`

## Requirements
- R1: Address 2*s holds the low word (thread mask, 32 bits) of source s and address 2*s+1 holds its high word, for s in 0..31. Address 64 is the write-only acknowledge register and reads as zero. Writes land on the clock edge where wr_en_i is high, and reads return the stored words combinationally.
- R2: After reset every table word reads zero, every entry is invalid, and pend_o is zero.
- R3: An entry whose valid bit (high word bit 31) is clear never sets any pending bit, whatever its low word, mode, polarity or input activity.
- R4: With the mode bit (high word bit 28) clear, the source is edge sensitive. A clear polarity bit (bit 27) selects the rising edge and a set one selects the falling edge. A detected edge latches a request that stays held after the input returns to idle.
- R5: With the mode bit set, the source is level sensitive. A clear polarity bit means active high and a set one means active low.
- R6: The vector field (high word bits 5:0) of a valid source holding a request sets that bit of pend_o. Several sources may share one vector. A vector value of 8 or more sets nothing. A set pending bit stays set until it is cleared.
- R7: Writing a value with bit s set to address 64 clears the latched request of source s. An edge source stays quiet afterwards until its next edge.
- R8: A one-cycle pulse on vec_clr_i bit v clears pend_o bit v. Bit v sets again if any valid source mapped to v still holds a request.
- R9: A level source whose input stays active after acknowledge raises its request again, so its vector bit returns after a clear.
- R10: The thread mask and the local/global flag (high word bit 30) are stored and read back, and they have no effect on routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | External interrupt lines, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 7 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 7 | Read address |
| rd_data_o | output | 32 | Read data, combinational |
| vec_clr_i | input | 8 | Per-vector clear pulse |
| pend_o | output | 8 | Pending vector register |

## Verification
The bench uses the default parameters: all 32 sources and 8 vectors. The sweep therefore covers every table slot and every source line. Sources rotate through the four mode and polarity combinations, and their vectors are spread so that each vector bit is driven several times. With only 65 addresses, the whole table can be read back after reset and after programming. Additional cases cover shared vectors, clearing before acknowledge, invalid entries and out-of-range vector numbers.

// File: rtl/irt_pkg.sv
package irt_pkg;
  localparam int HI_VALID  = 31;
  localparam int HI_GLOBAL = 30;
  localparam int HI_LEVEL  = 28;
  localparam int HI_POL    = 27;
  localparam int VEC_W     = 6;

  typedef struct packed {
    logic             valid;
    logic             glob;
    logic             level;
    logic             pol;
    logic [VEC_W-1:0] vec;
  } hi_cfg_t;

  function automatic hi_cfg_t unpack_hi(input logic [31:0] w);
    hi_cfg_t c;
    c.valid = w[HI_VALID];
    c.glob  = w[HI_GLOBAL];
    c.level = w[HI_LEVEL];
    c.pol   = w[HI_POL];
    c.vec   = w[VEC_W-1:0];
    return c;
  endfunction

  function automatic logic [31:0] pack_hi(input hi_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[HI_VALID]   = c.valid;
    w[HI_GLOBAL]  = c.glob;
    w[HI_LEVEL]   = c.level;
    w[HI_POL]     = c.pol;
    w[VEC_W-1:0]  = c.vec;
    return w;
  endfunction
endpackage

// File: rtl/irt_sync.sv
module irt_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irt_src.sv
module irt_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic valid_i,
  input  logic level_i,
  input  logic pol_i,
  input  logic ack_i,
  output logic req_o
);
  logic act, act_q, det, req_q;

  assign act = sync_i ^ pol_i;
  assign det = level_i ? act : (act & ~act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      act_q <= act;
      // a new detection wins over a same-cycle acknowledge
      req_q <= valid_i & (det | (req_q & ~ack_i));
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/irt_route.sv
module irt_route #(
  parameter int N_SRC = 32,
  parameter int N_VEC = 8,
  parameter int VEC_W = 6
) (
  input  logic [N_SRC-1:0]            req_i,
  input  logic [N_SRC-1:0]            valid_i,
  input  logic [N_SRC-1:0][VEC_W-1:0] vec_i,
  output logic [N_VEC-1:0]            hit_o
);
  always_comb begin
    hit_o = '0;
    for (int v = 0; v < N_VEC; v++) begin
      for (int s = 0; s < N_SRC; s++) begin
        if (req_i[s] && valid_i[s] && vec_i[s] == VEC_W'(v)) hit_o[v] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irt_ctrl.sv
module irt_ctrl
  import irt_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int N_VEC = 8,
  parameter int DW    = 32,
  localparam int AW   = $clog2(2*N_SRC+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic [N_VEC-1:0] vec_clr_i,
  output logic [N_VEC-1:0] pend_o
);
  localparam logic [AW-1:0] ACK_ADDR = AW'(2*N_SRC);

  logic [N_SRC-1:0]            sync;
  logic [N_SRC-1:0]            req;
  logic [N_SRC-1:0]            valid;
  logic [N_SRC-1:0]            ack;
  logic [N_SRC-1:0][VEC_W-1:0] vec;
  logic [N_VEC-1:0]            hit;
  logic [DW-1:0]               lo_q [N_SRC];
  hi_cfg_t                     hi_q [N_SRC];
  logic [N_VEC-1:0]            pend_q;

  irt_sync #(.W(N_SRC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(irq_i), .q_o(sync)
  );

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q[s] <= '0;
        hi_q[s] <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == AW'(2*s))   lo_q[s] <= wr_data_i;
        if (wr_addr_i == AW'(2*s+1)) hi_q[s] <= unpack_hi(32'(wr_data_i));
      end
    end

    assign ack[s]   = wr_en_i && (wr_addr_i == ACK_ADDR) && wr_data_i[s];
    assign valid[s] = hi_q[s].valid;
    assign vec[s]   = hi_q[s].vec;

    irt_src u_src (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sync_i (sync[s]),
      .valid_i(hi_q[s].valid),
      .level_i(hi_q[s].level),
      .pol_i  (hi_q[s].pol),
      .ack_i  (ack[s]),
      .req_o  (req[s])
    );
  end

  irt_route #(.N_SRC(N_SRC), .N_VEC(N_VEC), .VEC_W(VEC_W)) u_route (
    .req_i(req), .valid_i(valid), .vec_i(vec), .hit_o(hit)
  );

  // clear then re-evaluate: live requests win over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~vec_clr_i) | hit;
  end

  always_comb begin
    rd_data_o = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (rd_addr_i == AW'(2*s))   rd_data_o = lo_q[s];
      if (rd_addr_i == AW'(2*s+1)) rd_data_o = DW'(pack_hi(hi_q[s]));
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irt_ctrl_chk.sv
module irt_ctrl_chk #(
  parameter int N_SRC = 32,
  parameter int N_VEC = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_VEC-1:0] vec_clr_i,
  input logic [N_VEC-1:0] pend_o,
  input logic [N_SRC-1:0] req,
  input logic [N_SRC-1:0] valid,
  input logic [N_VEC-1:0] hit
);
  p_invalid_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((req & ~$past(valid)) == '0));

  p_pend_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_o) & ~$past(vec_clr_i) & ~pend_o) == '0));

  p_pend_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(hit)) == '0));

  p_clear_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(vec_clr_i) & ~$past(hit) & pend_o) == '0));

  p_reeval_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(hit) & ~pend_o) == '0));
endmodule

bind irt_ctrl irt_ctrl_chk #(.N_SRC(N_SRC), .N_VEC(N_VEC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .vec_clr_i(vec_clr_i),
  .pend_o   (pend_o),
  .req      (req),
  .valid    (valid),
  .hit      (hit)
);

// File: tb/sim_irt_ctrl.sv
module sim_irt_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_i = '0;
  logic        wr_en_i = 1'b0;
  logic [6:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [6:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic [7:0]  vec_clr_i = '0;
  logic [7:0]  pend_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  irt_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .vec_clr_i(vec_clr_i), .pend_o(pend_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 7'(addr); wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic clr(input logic [7:0] m);
    @(negedge clk_i);
    vec_clr_i = m;
    @(negedge clk_i);
    vec_clr_i = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic rd(input int addr, output logic [31:0] d);
    rd_addr_i = 7'(addr);
    #1 d = rd_data_o;
  endtask

  function automatic logic [31:0] hi(input bit v, input bit g, input bit lvl,
                                     input bit pol, input int vec);
    return {v, g, 1'b0, lvl, pol, 21'b0, 6'(vec)};
  endfunction

  initial begin : wdog
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    idle(3);
    rst_ni = 1'b1;
    idle(2);

    // R2: reset contents
    for (int a = 0; a < 65; a++) begin
      rd(a, d);
      chk(d, 32'h0, $sformatf("R2 reset word %0d", a));
    end
    chk(32'(pend_o), 32'h0, "R2 reset pend");

    // R3: invalid entry never raises
    wr(14, 32'hFFFF_FFFF);
    wr(15, hi(0, 1, 1, 0, 2));
    irq_i[7] = 1'b1; idle(6);
    chk(32'(pend_o), 32'h0, "R3 invalid entry level active");
    irq_i[7] = 1'b0; idle(3);
    irq_i[7] = 1'b1; idle(6);
    chk(32'(pend_o), 32'h0, "R3 invalid entry edge");
    irq_i[7] = 1'b0;
    wr(14, 32'h0); wr(15, 32'h0); idle(3);

    // R6: vector number out of range sets nothing
    wr(25, hi(1, 0, 0, 0, 40));
    irq_i[12] = 1'b1; idle(6);
    chk(32'(pend_o), 32'h0, "R6 vector 40 ignored");
    irq_i[12] = 1'b0;
    wr(25, 32'h0); wr(64, 32'h1 << 12); idle(3);

    // R6/R8: shared vector
    wr(9,  hi(1, 0, 0, 0, 5));
    wr(19, hi(1, 1, 0, 0, 5));
    irq_i[4] = 1'b1; irq_i[9] = 1'b1; idle(6);
    chk(32'(pend_o), 32'h20, "R6 shared vector raised");
    irq_i[4] = 1'b0; irq_i[9] = 1'b0;
    wr(64, 32'h1 << 4); clr(8'h20); idle(4);
    chk(32'(pend_o), 32'h20, "R8 shared vector still held by source 9");
    wr(64, 32'h1 << 9); clr(8'h20); idle(4);
    chk(32'(pend_o), 32'h0, "R7 shared vector drained");
    wr(9, 32'h0); wr(19, 32'h0); idle(2);

    // Sweep all sources through the four modes
    for (int s = 0; s < 32; s++) begin
      int  vec;
      bit  lvl, pol;
      logic [7:0] bitm;
      logic [31:0] hw, lw;
      vec  = (s * 3) % 8;
      lvl  = (s % 4) >= 2;
      pol  = (s % 2) == 1;
      bitm = 8'h1 << vec;
      hw   = hi(1, s[0] ^ s[1], lvl, pol, vec);
      lw   = 32'hC300_0000 | (32'(s) * 32'h0001_0101);
      irq_i[s] = pol; idle(4);
      wr(2*s, lw);
      wr(2*s+1, hw);
      idle(4);
      rd(2*s, d);   chk(d, lw, $sformatf("R1 R10 low word src %0d", s));
      rd(2*s+1, d); chk(d, hw, $sformatf("R1 high word src %0d", s));
      rd(64, d);    chk(d, 32'h0, "R1 ack reads zero");
      chk(32'(pend_o), 32'h0, $sformatf("R10 idle input quiet src %0d", s));
      irq_i[s] = ~pol; idle(6);
      chk(32'(pend_o), 32'(bitm),
          $sformatf("%s src %0d pol %0d vec %0d", lvl ? "R5" : "R4", s, pol, vec));
      if (lvl) begin
        wr(64, 32'h1 << s); clr(bitm); idle(5);
        chk(32'(pend_o), 32'(bitm), $sformatf("R9 level reasserts src %0d", s));
        irq_i[s] = pol; idle(4);
        wr(64, 32'h1 << s); clr(bitm); idle(5);
        chk(32'(pend_o), 32'h0, $sformatf("R7 level drained src %0d", s));
      end else begin
        irq_i[s] = pol; idle(4);
        chk(32'(pend_o), 32'(bitm), $sformatf("R4 edge held after idle src %0d", s));
        clr(bitm); idle(4);
        chk(32'(pend_o), 32'(bitm), $sformatf("R8 clear without ack src %0d", s));
        wr(64, 32'h1 << s); clr(bitm); idle(5);
        chk(32'(pend_o), 32'h0, $sformatf("R7 edge acked src %0d", s));
      end
      wr(2*s+1, 32'h0);
      irq_i[s] = 1'b0; idle(3);
      chk(32'(pend_o), 32'h0, $sformatf("R3 disabled src %0d", s));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule